// File: doc/BRIEF.md
# PLL Divider Code Solver

This block works out the feedback and reference divider codes for a clock-synthesis PLL. On a start strobe it takes a measured input frequency in hertz and a mode bit that picks a 133.33 MHz or a 100 MHz target. It then runs the arithmetic on a single shared serial divider. If every range check passes, it writes both codes through an index/data register port and waits a fixed settling time before it signals completion.

The reference code comes from a fixed ladder of ratio thresholds. The feedback code comes from a ratio scaled by one thousand. Three separate error flags name the check that failed: input clock out of range, ratio too large, or feedback code out of range. When a check fails, the block makes no register write and raises done at once. The settling delay is counted in pulses of a microsecond tick input, so it does not depend on the block clock frequency.

Top module: `pllcfg_solver`

## Requirements
- R1: The target frequency is 133,333,333 Hz when `fast_mode` is 1 at the accepted start, and 100,000,000 Hz when it is 0.
- R2: If `fin_hz` is below FIN_MIN_HZ or above FIN_MAX_HZ (inclusive bounds, defaults 5,000,000 and 70,000,000), the block sets `err_clk`, makes no register write and raises `done`.
- R3: The milli-ratio is the target divided by (`fin_hz` / 1000). Both divisions truncate.
- R4: The reference code `r_code` is 13 when the ratio is below 8600, 8 below 12900, 6 below 16100 and 0 below 64000. The first rung that matches wins.
- R5: A ratio of 64000 or more sets `err_ratio`, with no register write.
- R6: The feedback code is ratio × (R + 2) / 1000 − 2, truncated. A value outside 0..127 sets `err_f`, with no register write.
- R7: On success the block makes exactly two writes in consecutive cycles. The first has `reg_idx` 0x02 with the feedback code in `reg_dat`. The second has `reg_idx` 0x03 with the reference code, zero-extended. While `reg_wr` is low, `reg_idx` and `reg_dat` are 0.
- R8: After the second write, `done` rises once SETTLE_US cycles with `us_tick` high have been sampled, counting from the cycle after that write. The default is 30000, which is 30 ms with 1 µs ticks.
- R9: `done` is low from an accepted start until the result is ready. It goes high after success or after any error, and it holds until the next accepted start. A start that arrives while a calculation is running is ignored. At most one error flag is high at a time.
- R10: After reset every output is 0.
- R11: After success, `f_code` and `r_code` hold the written codes. After any error, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a calculation when idle |
| fast_mode | input | 1 | 1 selects the 133.33 MHz target, 0 the 100 MHz target |
| fin_hz | input | DW (32) | Measured PLL input frequency in Hz |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| f_code | output | FW (7) | Feedback divider code |
| r_code | output | 4 | Reference divider code |
| err_clk | output | 1 | Input frequency out of range |
| err_ratio | output | 1 | Ratio beyond the last ladder rung |
| err_f | output | 1 | Feedback code out of range |
| reg_wr | output | 1 | Register write strobe |
| reg_idx | output | 8 | Register index of the write |
| reg_dat | output | 8 | Register data of the write |
| done | output | 1 | Result ready (held) |

## Verification
Random in-range frequencies in both modes check the whole arithmetic chain against a truncating reference model, and they separate the two targets because the same input gives different codes in each mode. Directed pairs one kilohertz apart sit on each ladder threshold, so a wrong comparison or a rung in the wrong order shows up. The exact band edges and the values just outside them separate inclusive from exclusive range checks. A second instance with widened input bounds reaches the ratio and feedback-code errors, which the default bounds cannot produce. A start pulse sent mid-calculation shows whether busy starts are ignored.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KHZ,
      ST_RATIO,
      ST_FDIV,
      ST_WR_F,
      ST_WR_R,
      ST_SETTLE
   } pll_state_e;

   // reference-divider ladder: ascending ratio limits and the code chosen below each
   localparam int RUNGS = 4;
   localparam int unsigned RUNG_LIMIT [RUNGS] = '{8600, 12900, 16100, 64000};
   localparam logic [3:0]  RUNG_CODE  [RUNGS] = '{4'd13, 4'd8, 4'd6, 4'd0};

   localparam int unsigned MILLI = 1000;

endpackage

// File: rtl/pllcfg_divider.sv
// Restoring serial divider: one quotient bit per cycle, W cycles per division.
module pllcfg_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         fin_pulse,
   output logic [W-1:0] quo
);
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("pllcfg_divider: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  rem_q, quo_q, num_q, den_q;
   logic [CW-1:0] left_q;
   logic          run_q;
   logic [W:0]    shifted, trial;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      trial   = shifted - {1'b0, den_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q     <= '0;
         quo_q     <= '0;
         num_q     <= '0;
         den_q     <= '0;
         left_q    <= '0;
         run_q     <= 1'b0;
         fin_pulse <= 1'b0;
      end else begin
         fin_pulse <= 1'b0;
         if (start) begin
            rem_q  <= '0;
            quo_q  <= num;
            num_q  <= num;
            den_q  <= den;
            left_q <= CW'(W);
            run_q  <= 1'b1;
         end else if (run_q) begin
            if (!trial[W]) begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= shifted[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
               run_q     <= 1'b0;
               fin_pulse <= 1'b1;
            end
         end
      end
   end

   assign quo = quo_q;

   // R3: the result is the truncated quotient of the captured operands
   logic [2*W-1:0] chk_prod;
   assign chk_prod = {{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q};

   a_r3_quotient_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_pulse && den_q != '0) |->
         (chk_prod <= {{W{1'b0}}, num_q}) &&
         (({{W{1'b0}}, num_q} - chk_prod) < {{W{1'b0}}, den_q}));

endmodule

// File: rtl/pllcfg_rsel.sv
// Reference-code ladder: the lowest rung whose limit exceeds the ratio wins.
module pllcfg_rsel #(
   parameter int W = 32
) (
   input  logic [W-1:0] ratio,
   output logic [3:0]   code,
   output logic         miss
);
   import pllcfg_pkg::*;

   logic [RUNGS-1:0] below;

   generate
      for (genvar g = 0; g < RUNGS; g++) begin : g_rung
         assign below[g] = (ratio < W'(RUNG_LIMIT[g]));
         if (g > 0) begin : g_order
            if (RUNG_LIMIT[g] <= RUNG_LIMIT[g-1]) begin : g_bad_order
               $error("pllcfg_rsel: ladder limits must ascend");
            end
         end
      end
   endgenerate

   always_comb begin
      code = '0;
      for (int i = RUNGS - 1; i >= 0; i--) begin
         if (below[i]) code = RUNG_CODE[i];
      end
   end

   assign miss = ~below[RUNGS-1];

endmodule

// File: rtl/pllcfg_settle.sv
// Settling timer: counts TICKS microsecond pulses after being armed.
module pllcfg_settle #(
   parameter int unsigned TICKS = 30000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic tick,
   output logic expired
);
   localparam int CW = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   generate
      if (TICKS == 0) begin : g_bad_ticks
         $error("pllcfg_settle: TICKS must be at least 1");
      end
   endgenerate

   logic          active_q;
   logic [CW-1:0] cnt_q;

   assign expired = active_q && tick && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (arm) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (expired) begin
         active_q <= 1'b0;
      end else if (active_q && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R8: without a tick the settle count stands still
   a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !tick && !arm) |=> $stable(cnt_q));

endmodule

// File: rtl/pllcfg_solver.sv
module pllcfg_solver #(
   parameter int          DW         = 32,
   parameter int unsigned FIN_MIN_HZ = 5_000_000,
   parameter int unsigned FIN_MAX_HZ = 70_000_000,
   parameter int unsigned FAST_HZ    = 133_333_333,
   parameter int unsigned BASE_HZ    = 100_000_000,
   parameter int unsigned SETTLE_US  = 30_000,
   parameter int unsigned F_MAX      = 127,
   parameter logic [7:0]  F_IDX      = 8'h02,
   parameter logic [7:0]  R_IDX      = 8'h03,
   localparam int         FW         = $clog2(F_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          fast_mode,
   input  logic [DW-1:0] fin_hz,
   input  logic          us_tick,
   output logic [FW-1:0] f_code,
   output logic [3:0]    r_code,
   output logic          err_clk,
   output logic          err_ratio,
   output logic          err_f,
   output logic          reg_wr,
   output logic [7:0]    reg_idx,
   output logic [7:0]    reg_dat,
   output logic          done
);
   import pllcfg_pkg::*;

   generate
      if (DW < 32) begin : g_bad_dw
         $error("pllcfg_solver: DW must be at least 32");
      end
      if (FIN_MIN_HZ < MILLI || FIN_MIN_HZ > FIN_MAX_HZ) begin : g_bad_band
         $error("pllcfg_solver: input band must start at 1 kHz or above and be ordered");
      end
      if (F_MAX < 1 || F_MAX > 255) begin : g_bad_fmax
         $error("pllcfg_solver: F_MAX must fit the data byte");
      end
   endgenerate

   localparam logic [DW-1:0] LO_HZ   = DW'(FIN_MIN_HZ);
   localparam logic [DW-1:0] HI_HZ   = DW'(FIN_MAX_HZ);
   localparam logic [DW-1:0] FAST_T  = DW'(FAST_HZ);
   localparam logic [DW-1:0] BASE_T  = DW'(BASE_HZ);
   localparam logic [DW-1:0] KILO    = DW'(MILLI);
   localparam logic [DW-1:0] Q_LOW   = DW'(2);
   localparam logic [DW-1:0] Q_HIGH  = DW'(F_MAX + 2);

   pll_state_e    st_q;
   logic          mode_q;
   logic          div_go;
   logic [DW-1:0] div_num, div_den, div_q;
   logic          div_fin;
   logic [3:0]    r_pick, r_work;
   logic          r_miss;
   logic          settle_done;
   logic [DW-1:0] scale;
   logic [FW-1:0] f_q;
   logic [3:0]    r_q;

   pllcfg_divider #(.W(DW)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (div_go),
      .num       (div_num),
      .den       (div_den),
      .fin_pulse (div_fin),
      .quo       (div_q)
   );

   pllcfg_rsel #(.W(DW)) u_rsel (
      .ratio (div_q),
      .code  (r_pick),
      .miss  (r_miss)
   );

   pllcfg_settle #(.TICKS(SETTLE_US)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (st_q == ST_WR_R),
      .tick    (us_tick),
      .expired (settle_done)
   );

   assign scale = DW'(r_pick) + Q_LOW;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         mode_q    <= 1'b0;
         div_go    <= 1'b0;
         div_num   <= '0;
         div_den   <= '0;
         r_work    <= '0;
         f_q       <= '0;
         r_q       <= '0;
         err_clk   <= 1'b0;
         err_ratio <= 1'b0;
         err_f     <= 1'b0;
         done      <= 1'b0;
      end else begin
         div_go <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  done      <= 1'b0;
                  err_clk   <= 1'b0;
                  err_ratio <= 1'b0;
                  err_f     <= 1'b0;
                  f_q       <= '0;
                  r_q       <= '0;
                  mode_q    <= fast_mode;
                  if (fin_hz < LO_HZ || fin_hz > HI_HZ) begin
                     err_clk <= 1'b1;
                     done    <= 1'b1;
                  end else begin
                     div_num <= fin_hz;
                     div_den <= KILO;
                     div_go  <= 1'b1;
                     st_q    <= ST_KHZ;
                  end
               end
            end
            ST_KHZ: begin
               if (div_fin) begin
                  div_num <= mode_q ? FAST_T : BASE_T;
                  div_den <= div_q;
                  div_go  <= 1'b1;
                  st_q    <= ST_RATIO;
               end
            end
            ST_RATIO: begin
               if (div_fin) begin
                  if (r_miss) begin
                     err_ratio <= 1'b1;
                     done      <= 1'b1;
                     st_q      <= ST_IDLE;
                  end else begin
                     r_work  <= r_pick;
                     div_num <= div_q * scale;
                     div_den <= KILO;
                     div_go  <= 1'b1;
                     st_q    <= ST_FDIV;
                  end
               end
            end
            ST_FDIV: begin
               if (div_fin) begin
                  if (div_q < Q_LOW || div_q > Q_HIGH) begin
                     err_f <= 1'b1;
                     done  <= 1'b1;
                     st_q  <= ST_IDLE;
                  end else begin
                     f_q  <= FW'(div_q - Q_LOW);
                     r_q  <= r_work;
                     st_q <= ST_WR_F;
                  end
               end
            end
            ST_WR_F:   st_q <= ST_WR_R;
            ST_WR_R:   st_q <= ST_SETTLE;
            ST_SETTLE: begin
               if (settle_done) begin
                  done <= 1'b1;
                  st_q <= ST_IDLE;
               end
            end
            default:   st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      reg_wr  = 1'b0;
      reg_idx = '0;
      reg_dat = '0;
      if (st_q == ST_WR_F) begin
         reg_wr  = 1'b1;
         reg_idx = F_IDX;
         reg_dat = 8'(f_q);
      end else if (st_q == ST_WR_R) begin
         reg_wr  = 1'b1;
         reg_idx = R_IDX;
         reg_dat = 8'(r_q);
      end
   end

   assign f_code = f_q;
   assign r_code = r_q;

   // R7: the feedback write is always followed by the reference write
   a_r7_f_then_r: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_idx == F_IDX) |=> (reg_wr && reg_idx == R_IDX));

   // R7: the reference write never comes without the feedback write just before
   a_r7_r_after_f: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_idx == R_IDX) |-> $past(reg_wr && reg_idx == F_IDX));

   // R6: the written feedback code stays within its range
   a_r6_f_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_idx == F_IDX) |-> (reg_dat <= 8'(F_MAX)));

   // R9: a finished block does not write, and at most one error is raised
   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !reg_wr);

   a_r9_single_error: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_clk, err_ratio, err_f}));

   // R2: a clock error only appears right after a start
   a_r2_clk_err_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_clk) |-> $past(start));

   // R11: an error result leaves both codes at zero
   a_r11_codes_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (err_clk || err_ratio || err_f)) |-> (f_code == '0 && r_code == '0));

endmodule

// File: tb/pllcfg_solver_bench.sv
`timescale 1ns/1ps
module pllcfg_solver_bench;

   localparam int MAIN_SETTLE = 12;
   localparam int WIDE_SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b0;
   int   tick_ph = 0;
   int   cycle = 0;

   always #10 clk = ~clk;

   // main instance
   logic        m_start = 1'b0, m_fast = 1'b0;
   logic [31:0] m_fin = '0;
   logic [6:0]  m_f;
   logic [3:0]  m_r;
   logic        m_ec, m_er, m_ef, m_wr, m_done;
   logic [7:0]  m_idx, m_dat;

   // wide-band instance
   logic        w_start = 1'b0, w_fast = 1'b0;
   logic [31:0] w_fin = '0;
   logic [6:0]  w_f;
   logic [3:0]  w_r;
   logic        w_ec, w_er, w_ef, w_wr, w_done;
   logic [7:0]  w_idx, w_dat;

   pllcfg_solver #(.SETTLE_US(MAIN_SETTLE)) u_pllcfg_solver (
      .clk(clk), .rst_n(rst_n), .start(m_start), .fast_mode(m_fast), .fin_hz(m_fin),
      .us_tick(us_tick), .f_code(m_f), .r_code(m_r), .err_clk(m_ec), .err_ratio(m_er),
      .err_f(m_ef), .reg_wr(m_wr), .reg_idx(m_idx), .reg_dat(m_dat), .done(m_done));

   pllcfg_solver #(.SETTLE_US(WIDE_SETTLE), .FIN_MIN_HZ(1000), .FIN_MAX_HZ(2_000_000_000))
   u_pllcfg_solver_wide (
      .clk(clk), .rst_n(rst_n), .start(w_start), .fast_mode(w_fast), .fin_hz(w_fin),
      .us_tick(us_tick), .f_code(w_f), .r_code(w_r), .err_clk(w_ec), .err_ratio(w_er),
      .err_f(w_ef), .reg_wr(w_wr), .reg_idx(w_idx), .reg_dat(w_dat), .done(w_done));

   bit use_wide = 1'b0;
   logic       o_wr, o_done, o_ec, o_er, o_ef;
   logic [7:0] o_idx, o_dat;
   logic [6:0] o_f;
   logic [3:0] o_r;
   assign o_wr   = use_wide ? w_wr   : m_wr;
   assign o_done = use_wide ? w_done : m_done;
   assign o_ec   = use_wide ? w_ec   : m_ec;
   assign o_er   = use_wide ? w_er   : m_er;
   assign o_ef   = use_wide ? w_ef   : m_ef;
   assign o_idx  = use_wide ? w_idx  : m_idx;
   assign o_dat  = use_wide ? w_dat  : m_dat;
   assign o_f    = use_wide ? w_f    : m_f;
   assign o_r    = use_wide ? w_r    : m_r;

   int checks = 0;
   int errors = 0;
   bit reported = 1'b0;

   int wr_n = 0;
   int tick_n = 0;
   int wr_idx [2];
   int wr_dat [2];
   int wr_cyc [2];

   initial forever begin
      @(posedge clk);
      cycle++;
      tick_ph <= (tick_ph == 2) ? 0 : tick_ph + 1;
      us_tick <= (tick_ph == 0);
   end

   // write and settle-tick monitor, sampled away from the active edge
   initial forever begin
      @(negedge clk);
      if (o_wr) begin
         if (wr_n < 2) begin
            wr_idx[wr_n] = int'(o_idx);
            wr_dat[wr_n] = int'(o_dat);
            wr_cyc[wr_n] = cycle;
         end
         wr_n++;
      end else if (wr_n == 2 && !o_done) begin
         tick_n += int'(us_tick);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic void model(input longint fin, input bit fast, input longint lo,
                                 input longint hi, output bit ec, output bit er,
                                 output bit ef, output int fe, output int re);
      longint tgt, khz, ratio, q;
      ec = 0; er = 0; ef = 0; fe = 0; re = 0;
      if (fin < lo || fin > hi) begin
         ec = 1;
         return;
      end
      tgt   = fast ? 64'd133_333_333 : 64'd100_000_000;
      khz   = fin / 1000;
      ratio = tgt / khz;
      if (ratio < 8600)       re = 13;
      else if (ratio < 12900) re = 8;
      else if (ratio < 16100) re = 6;
      else if (ratio < 64000) re = 0;
      else begin
         er = 1;
         return;
      end
      q = ratio * (re + 2) / 1000 - 2;
      if (q < 0 || q > 127) begin
         ef = 1;
         re = 0;
         return;
      end
      fe = int'(q);
   endfunction

   task automatic run(input longint fin, input bit fast, input bit poke);
      bit ec, er, ef, ok;
      int fe, re, n;
      longint lo, hi;
      lo = use_wide ? 64'd1000 : 64'd5_000_000;
      hi = use_wide ? 64'd2_000_000_000 : 64'd70_000_000;
      model(fin, fast, lo, hi, ec, er, ef, fe, re);
      wr_n = 0;
      tick_n = 0;
      @(negedge clk);
      if (use_wide) begin w_fin = 32'(fin); w_fast = fast; w_start = 1'b1; end
      else          begin m_fin = 32'(fin); m_fast = fast; m_start = 1'b1; end
      @(negedge clk);
      w_start = 1'b0;
      m_start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         // R9: a start during a calculation must not disturb it
         m_fin = 32'd40_000_000;
         m_fast = ~fast;
         m_start = 1'b1;
         @(negedge clk);
         m_start = 1'b0;
      end
      n = 0;
      while (!o_done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(o_done == 1'b1, "R9", "done after run", longint'(o_done), 1);
      chk(o_ec == ec, "R2", "err_clk", longint'(o_ec), longint'(ec));
      chk(o_er == er, "R5", "err_ratio", longint'(o_er), longint'(er));
      chk(o_ef == ef, "R6", "err_f", longint'(o_ef), longint'(ef));
      chk(int'(o_f) == fe, "R1 R6 R11", "f_code", longint'(o_f), longint'(fe));
      chk(int'(o_r) == re, "R3 R4 R11", "r_code", longint'(o_r), longint'(re));
      ok = !(ec || er || ef);
      chk(wr_n == (ok ? 2 : 0), "R7", "write count", longint'(wr_n), ok ? 2 : 0);
      if (ok && wr_n == 2) begin
         chk(wr_idx[0] == 2, "R7", "first index", longint'(wr_idx[0]), 2);
         chk(wr_dat[0] == fe, "R7", "first data", longint'(wr_dat[0]), longint'(fe));
         chk(wr_idx[1] == 3, "R7", "second index", longint'(wr_idx[1]), 3);
         chk(wr_dat[1] == re, "R7", "second data", longint'(wr_dat[1]), longint'(re));
         chk(wr_cyc[1] == wr_cyc[0] + 1, "R7", "write spacing",
             longint'(wr_cyc[1] - wr_cyc[0]), 1);
         chk(tick_n == (use_wide ? WIDE_SETTLE : MAIN_SETTLE), "R8", "settle ticks",
             longint'(tick_n), use_wide ? WIDE_SETTLE : MAIN_SETTLE);
      end
      @(negedge clk);
      chk(o_done == 1'b1 && o_wr == 1'b0, "R9", "done held, no write",
          longint'({o_done, o_wr}), 2);
      if (!o_wr) chk(o_idx == 8'h00 && o_dat == 8'h00, "R7", "idle port bus",
                     longint'({o_idx, o_dat}), 0);
   endtask

   task automatic finish_up();
      if (!reported) begin
         reported = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 0);
      finish_up();
   end

   initial begin
      void'($urandom(32'd20_240_611));
      repeat (5) @(negedge clk);
      // R10: outputs idle in reset and just after it
      chk({m_f, m_r, m_ec, m_er, m_ef, m_wr, m_idx, m_dat, m_done} == '0, "R10",
          "outputs in reset", longint'({m_f, m_r, m_done}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({m_f, m_r, m_ec, m_er, m_ef, m_wr, m_idx, m_dat, m_done} == '0, "R10",
          "outputs after reset", longint'({m_f, m_r, m_done}), 0);

      use_wide = 1'b0;
      // band edges, R2
      run(64'd5_000_000, 1'b1, 1'b0);
      run(64'd70_000_000, 1'b0, 1'b0);
      run(64'd4_999_999, 1'b1, 1'b0);
      run(64'd70_000_001, 1'b0, 1'b0);
      run(64'd0, 1'b1, 1'b0);
      // same input, both targets, R1
      run(64'd33_333_333, 1'b1, 1'b0);
      run(64'd33_333_333, 1'b0, 1'b0);
      // ladder thresholds, R4
      run(64'd15_503_000, 1'b1, 1'b0);
      run(64'd15_504_000, 1'b1, 1'b0);
      run(64'd10_335_000, 1'b1, 1'b0);
      run(64'd10_336_000, 1'b1, 1'b0);
      run(64'd8_281_000, 1'b1, 1'b0);
      run(64'd8_282_000, 1'b1, 1'b0);
      // busy start ignored, R9
      run(64'd25_000_000, 1'b1, 1'b1);
      for (int i = 0; i < 24; i++) begin
         run(64'd5_000_000 + longint'($urandom % 65_000_001), 1'($urandom), 1'b0);
      end
      for (int i = 0; i < 4; i++) begin
         run(longint'($urandom), 1'($urandom), 1'b0);
      end

      // wide band reaches the ratio and feedback-code errors, R5 R6
      use_wide = 1'b1;
      run(64'd1000, 1'b1, 1'b0);
      run(64'd999, 1'b0, 1'b0);
      run(64'd1_000_000_000, 1'b0, 1'b0);
      run(64'd1_000_000_000, 1'b1, 1'b0);
      run(64'd20_000_000, 1'b1, 1'b0);
      run(64'd2_000, 1'b0, 1'b0);

      finish_up();
   end

endmodule